// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block sits between the external bus of a boot-block flash device and its internal operation sequencer. It samples the chip-enable and write-enable strobes synchronously. It treats each write cycle as complete at the first clock edge after either strobe rises, and it decodes the low byte of the written value as a command. It issues one-cycle start requests for program, block erase, erase suspend and erase resume, together with the latched target address and data. It also holds a read-mode select that chooses between array data and the status register.

While an operation runs or is suspended, the block accepts only a restricted set of commands. It learns the end of an operation from the sequencer's ready flag. A separate functional reset input aborts any running operation and returns the block to array-read mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After `rst_ni` is released, `rd_status_o` is 0 (array read mode) and no request pulse is active.
- R2: A write of 40h or 10h followed by a second write starts a program. `prog_start_o` pulses for one cycle, in the cycle after the second write ends. `tgt_addr_o` and `tgt_data_o` hold that write's address and data, with the upper byte zeroed in byte mode. `rd_status_o` becomes 1.
- R3: If the second write after a program setup is all ones, the program is cancelled and no start pulse occurs. All ones means low byte FFh in byte mode (`byte_mode_i`=1), or FFFFh in word mode. In word mode, 00FFh is a normal program. After a cancel the block is in status mode.
- R4: Writing 20h and then D0h pulses `erase_start_o`, with `tgt_addr_o` taken from the D0h write. Any other second code starts nothing and returns to idle in status mode.
- R5: The address and data of a write are those present when the first of `ce_ni` or `we_ni` rises. Changes made while the other strobe is still low are ignored.
- R6: While a program runs, no command starts anything or changes the read mode: FFh, 20h and B0h have no effect, and `rd_status_o` stays 1.
- R7: While an erase runs, B0h pulses `suspend_o` and FFh is ignored. Until `ready_i` reports the suspend, only status reads are honoured.
- R8: While suspended, FFh selects array read, 70h selects status, and D0h pulses `resume_o`. Program and erase setup codes are ignored.
- R9: Once `ready_i` rises again after an operation, every command is valid again.
- R10: `hw_rst_ni` low during a program, erase or suspend pulses `abort_o` in the next cycle and forces array read mode. Writes are ignored while `hw_rst_ni` is low.
- R11: In idle, unrecognised codes leave the state and read mode unchanged. Only `data_i[7:0]` is decoded as a command: 70h is read status, FFh is read array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_rst_ni | input | 1 | Functional reset pin, active low, aborts operations |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| byte_mode_i | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus write data |
| ready_i | input | 1 | Sequencer ready (status bit 7) |
| prog_start_o | output | 1 | Program start request pulse |
| erase_start_o | output | 1 | Block erase start request pulse |
| suspend_o | output | 1 | Erase suspend request pulse |
| resume_o | output | 1 | Erase resume request pulse |
| abort_o | output | 1 | Operation abort pulse |
| tgt_addr_o | output | ADDR_W | Latched target address |
| tgt_data_o | output | DATA_W | Latched target data |
| rd_status_o | output | 1 | 1 = reads return status, 0 = array |

## Verification
A wrong internal state shows up within one cycle of the end of the next write. It appears either as a request pulse that should not occur or one that is missing, or as `rd_status_o` taking the wrong value after a read-mode command. A state that does not leave busy on time only becomes visible at the first command written after `ready_i` rises, because that command is then ignored. A scoreboard matches every request pulse, with its address and data, against the sequence the bench expects, so any extra pulse is caught in the cycle it appears.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG_SETUP, ST_ERASE_SETUP, ST_PROG_BUSY,
    ST_CANCEL, ST_ERASE_BUSY, ST_SUSP_WAIT, ST_SUSPENDED
  } fsm_state_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_RD_ARRAY, CMD_RD_STATUS, CMD_PROG_SETUP,
    CMD_ERASE_SETUP, CMD_CONFIRM, CMD_SUSPEND
  } cmd_kind_e;

  localparam logic [7:0] OP_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_RD_STATUS  = 8'h70;
  localparam logic [7:0] OP_PROG_A     = 8'h40;
  localparam logic [7:0] OP_PROG_B     = 8'h10;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_SUSPEND    = 8'hB0;
endpackage

// File: rtl/fcsm_bus_capture.sv
module fcsm_bus_capture #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic wr_act, act_q;

  // write is active only while both strobes are low; first rise ends it
  assign wr_act = ~ce_ni & ~we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      act_q <= wr_act;
      if (wr_act) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

  assign commit_o = act_q & ~wr_act;

  AST_COMMIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R5
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !wr_act) |=> $stable(addr_o)); // R5
endmodule

// File: rtl/fcsm_cmd_decode.sv
module fcsm_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              byte_mode_i,
  output cmd_kind_e         kind_o,
  output logic              all_ones_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int LO_W = 8;
  logic [LO_W-1:0] code;

  assign code = data_i[LO_W-1:0];

  always_comb begin
    unique case (code)
      OP_RD_ARRAY:           kind_o = CMD_RD_ARRAY;
      OP_RD_STATUS:          kind_o = CMD_RD_STATUS;
      OP_PROG_A, OP_PROG_B:  kind_o = CMD_PROG_SETUP;
      OP_ERASE:              kind_o = CMD_ERASE_SETUP;
      OP_CONFIRM:            kind_o = CMD_CONFIRM;
      OP_SUSPEND:            kind_o = CMD_SUSPEND;
      default:               kind_o = CMD_NONE;
    endcase
  end

  generate
    if (DATA_W > LO_W) begin : g_wide
      logic hi_ones;
      assign hi_ones    = &data_i[DATA_W-1:LO_W];
      assign all_ones_o = (&code) & (byte_mode_i | hi_ones);
      assign wdata_o    = byte_mode_i ? {{(DATA_W-LO_W){1'b0}}, code} : data_i;
    end else begin : g_narrow
      logic unused_mode;
      assign unused_mode = byte_mode_i;
      assign all_ones_o  = &code;
      assign wdata_o     = data_i;
    end
  endgenerate

  always_comb begin
    AST_CANCEL_NEEDS_LOW_FF: assert (!all_ones_o || code == OP_RD_ARRAY); // R3
  end
endmodule

// File: rtl/fcsm_done_track.sv
module fcsm_done_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ready_i,
  output logic done_o
);
  logic seen_low_q;

  // ready may still be high for a cycle after a start; wait for it to drop first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_low_q <= 1'b0;
    else if (arm_i) seen_low_q <= 1'b0;
    else if (!ready_i) seen_low_q <= 1'b1;
  end

  assign done_o = ready_i & seen_low_q & ~arm_i;

  AST_DONE_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && ready_i) |=> !done_o); // R9
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              byte_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              prog_start_o,
  output logic              erase_start_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic              abort_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic              rd_status_o
);
  fsm_state_e        state_q, state_d;
  logic              commit_raw, commit;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data, wdata;
  cmd_kind_e         kind;
  logic              all_ones, done, arm;
  logic              rd_status_d, prog_d, erase_d, susp_d, resume_d, abort_d, load_tgt;
  logic              op_active;

  fcsm_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .addr_i, .data_i,
    .commit_o(commit_raw), .addr_o(cap_addr), .data_o(cap_data)
  );

  fcsm_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .data_i(cap_data), .byte_mode_i, .kind_o(kind),
    .all_ones_o(all_ones), .wdata_o(wdata)
  );

  fcsm_done_track u_trk (
    .clk_i, .rst_ni, .arm_i(arm), .ready_i, .done_o(done)
  );

  assign commit    = commit_raw & hw_rst_ni;
  assign op_active = state_q inside {ST_PROG_BUSY, ST_ERASE_BUSY, ST_SUSP_WAIT, ST_SUSPENDED};

  always_comb begin
    state_d     = state_q;
    rd_status_d = rd_status_o;
    prog_d      = 1'b0;
    erase_d     = 1'b0;
    susp_d      = 1'b0;
    resume_d    = 1'b0;
    abort_d     = 1'b0;
    load_tgt    = 1'b0;
    arm         = 1'b0;
    if (!hw_rst_ni) begin
      state_d     = ST_IDLE;
      rd_status_d = 1'b0;
      abort_d     = op_active;
    end else begin
      unique case (state_q)
        ST_IDLE: if (commit) begin
          unique case (kind)
            CMD_RD_ARRAY:  rd_status_d = 1'b0;
            CMD_RD_STATUS: rd_status_d = 1'b1;
            CMD_PROG_SETUP: begin
              state_d     = ST_PROG_SETUP;
              rd_status_d = 1'b1;
            end
            CMD_ERASE_SETUP: begin
              state_d     = ST_ERASE_SETUP;
              rd_status_d = 1'b1;
            end
            default: ;
          endcase
        end
        ST_PROG_SETUP: if (commit) begin
          rd_status_d = 1'b1;
          if (all_ones) begin
            state_d = ST_CANCEL;
          end else begin
            state_d  = ST_PROG_BUSY;
            prog_d   = 1'b1;
            load_tgt = 1'b1;
            arm      = 1'b1;
          end
        end
        ST_ERASE_SETUP: if (commit) begin
          rd_status_d = 1'b1;
          if (kind == CMD_CONFIRM) begin
            state_d  = ST_ERASE_BUSY;
            erase_d  = 1'b1;
            load_tgt = 1'b1;
            arm      = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_PROG_BUSY: if (done) state_d = ST_IDLE;
        ST_CANCEL:    if (ready_i) state_d = ST_IDLE;
        ST_ERASE_BUSY: begin
          if (done) begin
            state_d = ST_IDLE;
          end else if (commit && kind == CMD_SUSPEND) begin
            state_d = ST_SUSP_WAIT;
            susp_d  = 1'b1;
          end
        end
        ST_SUSP_WAIT: if (ready_i) state_d = ST_SUSPENDED;
        ST_SUSPENDED: if (commit) begin
          unique case (kind)
            CMD_RD_ARRAY:  rd_status_d = 1'b0;
            CMD_RD_STATUS: rd_status_d = 1'b1;
            CMD_CONFIRM: begin
              state_d     = ST_ERASE_BUSY;
              rd_status_d = 1'b1;
              resume_d    = 1'b1;
              arm         = 1'b1;
            end
            default: ;
          endcase
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      rd_status_o   <= 1'b0;
      prog_start_o  <= 1'b0;
      erase_start_o <= 1'b0;
      suspend_o     <= 1'b0;
      resume_o      <= 1'b0;
      abort_o       <= 1'b0;
      tgt_addr_o    <= '0;
      tgt_data_o    <= '0;
    end else begin
      state_q       <= state_d;
      rd_status_o   <= rd_status_d;
      prog_start_o  <= prog_d;
      erase_start_o <= erase_d;
      suspend_o     <= susp_d;
      resume_o      <= resume_d;
      abort_o       <= abort_d;
      if (load_tgt) begin
        tgt_addr_o <= cap_addr;
        tgt_data_o <= wdata;
      end
    end
  end

  AST_ONE_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, erase_start_o, suspend_o, resume_o, abort_o})); // R2
  AST_PROG_AFTER_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> $past(state_q == ST_PROG_SETUP)); // R2
  AST_NO_PROG_ON_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG_SETUP && commit && all_ones) |=> !prog_start_o); // R3
  AST_ERASE_CONFIRMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> $past(kind == CMD_CONFIRM && state_q == ST_ERASE_SETUP)); // R4
  AST_PROG_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG_BUSY && hw_rst_ni) |=> (!erase_start_o && !suspend_o && rd_status_o)); // R6
  AST_SUSP_FROM_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> $past(state_q == ST_ERASE_BUSY)); // R7
  AST_RESUME_FROM_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> $past(state_q == ST_SUSPENDED)); // R8
  AST_ABORT_ON_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(!hw_rst_ni) && !rd_status_o)); // R10
endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int AW = 19;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, hw_n = 1'b1, ce_n = 1'b1, we_n = 1'b1, bmode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic ready;
  logic prog_s, erase_s, susp_s, res_s, abort_s, rd_st;
  logic [AW-1:0] t_addr;
  logic [DW-1:0] t_data;

  int checks = 0, fails = 0, op_len = 40;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hw_rst_ni(hw_n), .ce_ni(ce_n), .we_ni(we_n),
    .byte_mode_i(bmode), .addr_i(addr), .data_i(data), .ready_i(ready),
    .prog_start_o(prog_s), .erase_start_o(erase_s), .suspend_o(susp_s),
    .resume_o(res_s), .abort_o(abort_s), .tgt_addr_o(t_addr),
    .tgt_data_o(t_data), .rd_status_o(rd_st)
  );

  // sequencer model
  int cnt, sdly;
  logic susp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin ready <= 1'b1; cnt <= 0; susp <= 1'b0; sdly <= 0; end
    else if (abort_s) begin ready <= 1'b1; cnt <= 0; susp <= 1'b0; end
    else if (prog_s || erase_s) begin ready <= 1'b0; cnt <= op_len; end
    else if (susp_s) begin susp <= 1'b1; sdly <= 3; end
    else if (res_s) begin susp <= 1'b0; ready <= 1'b0; end
    else if (susp) begin
      if (sdly > 0) begin sdly <= sdly - 1; if (sdly == 1) ready <= 1'b1; end
    end else if (cnt > 0) begin
      cnt <= cnt - 1; if (cnt == 1) ready <= 1'b1;
    end
  end

  // scoreboard: 0 prog, 1 erase, 2 suspend, 3 resume, 4 abort
  typedef struct { int kind; logic [AW-1:0] a; logic [DW-1:0] d; string req; } exp_t;
  exp_t q[$];

  task automatic expect_req(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    exp_t e;
    e.kind = k; e.a = a; e.d = d; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] v;
      v = {abort_s, res_s, susp_s, erase_s, prog_s};
      if (v != 0) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R6 unexpected request: act=%b exp=none", v);
        end else begin
          exp_t e;
          int k;
          e = q.pop_front();
          k = v[0] ? 0 : v[1] ? 1 : v[2] ? 2 : v[3] ? 3 : 4;
          if ($countones(v) != 1 || k != e.kind) begin
            fails++;
            $display("FAIL %s request kind: act=%b exp=%0d", e.req, v, e.kind);
          end else if (k < 2 && (t_addr != e.a || (k == 0 && t_data != e.d))) begin
            fails++;
            $display("FAIL %s target: act=%h/%h exp=%h/%h", e.req, t_addr, t_data, e.a, e.d);
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; data = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    @(negedge clk); we_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    repeat (3) @(negedge clk);
    while (!ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_status after reset", rd_st, 0);
    chk("R1 no pulses after reset", {prog_s, erase_s, susp_s, res_s, abort_s}, 0);

    // R11 command decode in idle
    wr(0, 16'h1270); chk("R11 word-mode low-byte 70h", rd_st, 1);
    wr(0, 16'h0055); chk("R11 unknown code keeps mode", rd_st, 1);
    wr(0, 16'h00D0); chk("R11 confirm in idle ignored", rd_st, 1);
    wr(0, 16'h00FF); chk("R11 read array", rd_st, 0);
    wr(0, 16'h0033); chk("R11 unknown code keeps array", rd_st, 0);

    // R2 program, word mode, 40h
    wr(0, 16'h0040);
    expect_req(0, 19'h12345, 16'hA55A, "R2");
    wr(19'h12345, 16'hA55A);
    chk("R2 status after program start", rd_st, 1);
    // R6 commands during program
    wr(0, 16'h00FF); chk("R6 read array ignored", rd_st, 1);
    wr(0, 16'h0020);
    wr(0, 16'h00B0); chk("R6 still status", rd_st, 1);
    wait_ready();
    wr(0, 16'h00FF); chk("R9 read array after program", rd_st, 0);

    // R2 program, byte mode, 10h; upper byte zeroed
    bmode = 1;
    wr(0, 16'h0010);
    expect_req(0, 19'h00007, 16'h0034, "R2 byte");
    wr(19'h00007, 16'h1234);
    wait_ready();

    // R3 cancel in byte mode
    wr(0, 16'h0040);
    wr(19'h00100, 16'h12FF);
    chk("R3 byte cancel status", rd_st, 1);
    repeat (2) @(negedge clk);
    wr(0, 16'h00FF); chk("R3 commands valid after cancel", rd_st, 0);
    bmode = 0;
    wr(0, 16'h0040);
    wr(19'h00200, 16'hFFFF);
    chk("R3 word cancel status", rd_st, 1);
    repeat (2) @(negedge clk);
    wr(0, 16'h0040);
    expect_req(0, 19'h00300, 16'h00FF, "R3 word 00FF programs");
    wr(19'h00300, 16'h00FF);
    wait_ready();

    // R4 erase
    wr(0, 16'h0020);
    expect_req(1, 19'h40000, 16'h0, "R4");
    wr(19'h40000, 16'h00D0);
    wait_ready();
    wr(0, 16'h0020);
    wr(19'h40000, 16'h0070);
    chk("R4 bad confirm to status", rd_st, 1);
    wr(0, 16'h00FF); chk("R4 idle after bad confirm", rd_st, 0);

    // R5 address latched at first rising strobe
    wr(0, 16'h0020);
    expect_req(1, 19'h21111, 16'h0, "R5");
    @(negedge clk); addr = 19'h21111; data = 16'h00D0; ce_n = 0; we_n = 0;
    @(negedge clk);
    @(negedge clk); we_n = 1;
    @(negedge clk); addr = 19'h3FFFF; data = 16'h0040;
    @(negedge clk); ce_n = 1;
    wait_ready();

    // R7 / R8 suspend and resume
    wr(0, 16'h0020);
    expect_req(1, 19'h50000, 16'h0, "R7 erase");
    wr(19'h50000, 16'h00D0);
    wr(0, 16'h00FF); chk("R7 read array ignored in erase", rd_st, 1);
    expect_req(2, 0, 0, "R7");
    wr(0, 16'h00B0);
    wait_ready();
    wr(0, 16'h0040);
    wr(0, 16'h0020);
    wr(0, 16'h00FF); chk("R8 read array while suspended", rd_st, 0);
    wr(0, 16'h0070); chk("R8 status while suspended", rd_st, 1);
    wr(0, 16'h00FF);
    expect_req(3, 0, 0, "R8");
    wr(0, 16'h00D0);
    chk("R8 status after resume", rd_st, 1);
    wait_ready();
    wr(0, 16'h00FF); chk("R9 valid after erase", rd_st, 0);

    // R10 functional reset aborts a program
    wr(0, 16'h0040);
    expect_req(0, 19'h00010, 16'h0F0F, "R10 prog");
    wr(19'h00010, 16'h0F0F);
    repeat (3) @(negedge clk);
    expect_req(4, 0, 0, "R10");
    hw_n = 0;
    repeat (3) @(negedge clk);
    chk("R10 array mode after abort", rd_st, 0);
    wr(0, 16'h0070); chk("R10 writes ignored while low", rd_st, 0);
    hw_n = 1;
    wr(0, 16'h0070); chk("R10 commands after release", rd_st, 1);

    repeat (5) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing requests: act=%0d exp=0", q.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R9 watchdog expired: act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule